// File: doc/BRIEF.md
# Control-Space Register Decoder

This block sits on the processor's 16-bit word bus and answers accesses made in control space (function code 3) whose byte-address bit 3 is set. That register layer holds four resources: a read-only window onto a 32-byte identification ROM, an 8-bit diagnostic register that drives a row of LEDs, a bus-error register that only hardware can load, and an 8-bit system-enable register. The system-enable bits leave the block as plain control levels: parity generation and checking, DMA-by-device enable, a global interrupt enable, three software interrupt requests and the boot/normal state flag.

The block also steers boot-time fetches. Reset leaves the machine in boot state. While the state flag is clear, every supervisor program read (function code 6) is answered with boot EPROM data, whatever its address. Any access that the block does not claim passes unchanged to a downstream strobe pair, so the MMU layer and memory behind it can answer it. Read data and the forward strobes are combinational in the current cycle. Register writes take effect at the clock edge that ends the write cycle.

Top module: `ctlsp_regdec`

## Requirements
- R1: An access is claimed as a register access only when `fc` is 3 and `addr[3]` is 1. `addr[2:1]` then selects the resource: 0 is the ID ROM, 1 the diagnostic register, 2 the bus-error register and 3 the system-enable register.
- R2: A claimed read of the ID ROM drives `idrom_addr` from `addr[15:11]`, so successive bytes lie 0x800 bytes apart. It returns `{idrom_data, 8'h00}` on `rdata`.
- R3: A write to the diagnostic register with `be[0]` high stores `wdata[7:0]`. A read returns that value in the low byte, with the upper byte at zero. `led_on` is the bitwise inverse of the stored value, so a 0 bit lights its LED.
- R4: The bus-error register loads `berr_info` when `berr_cap` is high and reads back as `{8'h00, value}`. Processor writes to it are ignored, and so are writes to the ID ROM. When a capture and a processor write to that register fall in the same cycle, the captured value is kept.
- R5: A write to the system-enable register stores `wdata[7:0]` only when `be[0]` is high; a write with only `be[1]` high leaves it unchanged. Bit 0 drives `par_gen_en`, bit 4 `par_chk_en`, bit 5 `dvma_en`, bit 6 `irq_en` and bit 7 `normal_mode`. A read returns the value in the low byte.
- R6: `swirq[k]` (request levels k+1, for k = 0..2) is high only when system-enable bit k+1 and bit 6 are both set.
- R7: While system-enable bit 7 is 0, a read with `fc` = 6 is claimed and returns `rom_data`, with `rom_addr` = `addr[14:1]`. Once bit 7 is 1, such reads are forwarded.
- R8: Reset clears the diagnostic, bus-error and system-enable registers. All LEDs are then lit, every control output is low, and the block is in boot state.
- R9: An access that is not claimed sets `fwd_rd` (or `fwd_wr`) equal to its strobe and changes no register. Writes are never claimed outside the register layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc | input | 3 | Processor function code |
| addr | input | 23 | Word address, bits 23:1 of the byte address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for claimed reads |
| fwd_rd | output | 1 | Read forwarded downstream |
| fwd_wr | output | 1 | Write forwarded downstream |
| rom_addr | output | 14 | Boot EPROM word index |
| rom_data | input | 16 | Boot EPROM word |
| idrom_addr | output | 5 | ID ROM byte index |
| idrom_data | input | 8 | ID ROM byte |
| berr_cap | input | 1 | Load strobe for the bus-error register |
| berr_info | input | 8 | Bus-error cause to capture |
| led_on | output | 8 | LED drive, 1 = lit |
| par_gen_en | output | 1 | Parity generation enable |
| par_chk_en | output | 1 | Parity check enable |
| dvma_en | output | 1 | Device DMA enable |
| irq_en | output | 1 | Global interrupt enable |
| swirq | output | 3 | Gated software interrupt requests, levels 1 to 3 |
| normal_mode | output | 1 | 0 = boot state, 1 = normal state |

## Verification
The hardware capture of the bus-error register and a processor write to that same register can fall in one clock. The bench drives `berr_cap` with one cause value in the same cycle that it writes a different value to offset 0xC. It then reads the register back and expects the captured cause. The second overlap is the boot redirect against the register layer: the bench sweeps every function code and every low offset in boot state and again in normal state. For each access it compares claim and forward against the decode rules and checks that function-code-6 reads return the EPROM word computed from the address.

// File: rtl/ctlsp_pkg.sv
package ctlsp_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDROM,
        SEL_DIAG,
        SEL_BERR,
        SEL_SYSEN,
        SEL_BOOT
    } csel_e;

    localparam logic [2:0] FC_CTRL     = 3'd3;
    localparam logic [2:0] FC_SUP_PROG = 3'd6;

    // system-enable bit positions (decoded by neighbouring logic)
    localparam int SE_PGEN   = 0;
    localparam int SE_SWI_LO = 1;
    localparam int SE_PCHK   = 4;
    localparam int SE_DVMA   = 5;
    localparam int SE_IEN    = 6;
    localparam int SE_NORMAL = 7;

    typedef struct packed {
        logic [7:0] diag;
        logic [7:0] berr;
        logic [7:0] sysen;
    } cregs_t;

endpackage

// File: rtl/ctlsp_decode.sv
module ctlsp_decode
    import ctlsp_pkg::*;
#(
    parameter int ADDR_HI = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         fc,
    input  logic [ADDR_HI:1]   addr,
    input  logic               rd,
    input  logic               wr,
    input  logic               boot_state,
    output csel_e              sel,
    output logic               fwd_rd,
    output logic               fwd_wr
);

    logic reg_layer;

    always_comb begin
        reg_layer = (fc == FC_CTRL) && addr[3];
        sel       = SEL_NONE;
        if (reg_layer) begin
            unique case (addr[2:1])
                2'd0: sel = SEL_IDROM;
                2'd1: sel = SEL_DIAG;
                2'd2: sel = SEL_BERR;
                default: sel = SEL_SYSEN;
            endcase
        end else if (fc == FC_SUP_PROG && boot_state && rd) begin
            sel = SEL_BOOT;
        end
        fwd_rd = rd && (sel == SEL_NONE);
        fwd_wr = wr && !reg_layer;
    end

    // R9: a control-space register-layer access is never forwarded
    p_layer_claimed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fc == FC_CTRL && addr[3]) |-> (!fwd_rd && !fwd_wr));

endmodule

// File: rtl/ctlsp_regs.sv
module ctlsp_regs
    import ctlsp_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  csel_e            sel,
    input  logic             wr,
    input  logic             be_lo,
    input  logic [REG_W-1:0] wbyte,
    input  logic             berr_cap,
    input  logic [REG_W-1:0] berr_info,
    output logic [REG_W-1:0] diag_q,
    output logic [REG_W-1:0] berr_q,
    output logic [REG_W-1:0] sysen_q
);

    cregs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (berr_cap) begin
            st_d.berr = berr_info;
        end
        if (wr && be_lo) begin
            unique case (sel)
                SEL_DIAG:  st_d.diag  = wbyte;
                SEL_SYSEN: st_d.sysen = wbyte;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign diag_q  = st_q.diag;
    assign berr_q  = st_q.berr;
    assign sysen_q = st_q.sysen;

    // R4: without a capture strobe the bus-error register holds
    p_berr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_cap |=> $stable(berr_q));

    // R5: low-byte write lands in system-enable
    p_sysen_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && be_lo && sel == SEL_SYSEN) |=> (sysen_q == $past(wbyte)));

    // R5: write without the low byte enable changes nothing
    p_sysen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && be_lo && sel == SEL_SYSEN) |=> $stable(sysen_q));

    // R3: diagnostic register only moves on its own enabled write
    p_diag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && be_lo && sel == SEL_DIAG) |=> $stable(diag_q));

endmodule

// File: rtl/ctlsp_regdec.sv
module ctlsp_regdec
    import ctlsp_pkg::*;
#(
    parameter int ADDR_HI = 23,
    parameter int DW      = 16,
    parameter int ROM_AW  = 14,
    parameter int ID_AW   = 5,
    parameter int REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         fc,
    input  logic [ADDR_HI:1]   addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [1:0]         be,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               fwd_rd,
    output logic               fwd_wr,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [DW-1:0]      rom_data,
    output logic [ID_AW-1:0]   idrom_addr,
    input  logic [REG_W-1:0]   idrom_data,
    input  logic               berr_cap,
    input  logic [REG_W-1:0]   berr_info,
    output logic [REG_W-1:0]   led_on,
    output logic               par_gen_en,
    output logic               par_chk_en,
    output logic               dvma_en,
    output logic               irq_en,
    output logic [2:0]         swirq,
    output logic               normal_mode
);

    localparam int ID_LSB = 11;
    localparam int PAD_W  = DW - REG_W;

    csel_e            sel;
    logic [REG_W-1:0] diag_q, berr_q, sysen_q;
    logic             unused_bits;

    assign unused_bits = ^{wdata[DW-1:REG_W], be[1], addr[ADDR_HI:ID_LSB+ID_AW]};

    ctlsp_decode #(.ADDR_HI(ADDR_HI)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .fc         (fc),
        .addr       (addr),
        .rd         (rd),
        .wr         (wr),
        .boot_state (!sysen_q[SE_NORMAL]),
        .sel        (sel),
        .fwd_rd     (fwd_rd),
        .fwd_wr     (fwd_wr)
    );

    ctlsp_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr        (wr),
        .be_lo     (be[0]),
        .wbyte     (wdata[REG_W-1:0]),
        .berr_cap  (berr_cap),
        .berr_info (berr_info),
        .diag_q    (diag_q),
        .berr_q    (berr_q),
        .sysen_q   (sysen_q)
    );

    assign rom_addr   = addr[ROM_AW:1];
    assign idrom_addr = addr[ID_LSB+ID_AW-1:ID_LSB];

    always_comb begin
        unique case (sel)
            SEL_IDROM: rdata = {idrom_data, {PAD_W{1'b0}}};
            SEL_DIAG:  rdata = {{PAD_W{1'b0}}, diag_q};
            SEL_BERR:  rdata = {{PAD_W{1'b0}}, berr_q};
            SEL_SYSEN: rdata = {{PAD_W{1'b0}}, sysen_q};
            SEL_BOOT:  rdata = rom_data;
            default:   rdata = '0;
        endcase
    end

    assign led_on      = ~diag_q;
    assign par_gen_en  = sysen_q[SE_PGEN];
    assign par_chk_en  = sysen_q[SE_PCHK];
    assign dvma_en     = sysen_q[SE_DVMA];
    assign irq_en      = sysen_q[SE_IEN];
    assign normal_mode = sysen_q[SE_NORMAL];

    for (genvar k = 0; k < 3; k++) begin : g_swi
        assign swirq[k] = sysen_q[SE_SWI_LO+k] && sysen_q[SE_IEN];
    end

    // R6: no software request without the global enable
    p_swirq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|swirq) |-> irq_en);

    // R7: in boot state a supervisor program read is served from EPROM
    p_boot_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && fc == FC_SUP_PROG && !normal_mode) |-> (!fwd_rd && rdata == rom_data));

    // R8: the cycle after reset leaves the block in boot state with LEDs lit
    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (!normal_mode && led_on == '1 && swirq == '0));

endmodule

// File: tb/ctlsp_regdec_test.sv
`timescale 1ns/100ps
module ctlsp_regdec_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fc = '0;
    logic [23:1] addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [1:0]  be = 2'b00;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        fwd_rd, fwd_wr;
    logic [13:0] rom_addr;
    logic [15:0] rom_data;
    logic [4:0]  idrom_addr;
    logic [7:0]  idrom_data;
    logic        berr_cap = 1'b0;
    logic [7:0]  berr_info = '0;
    logic [7:0]  led_on;
    logic        par_gen_en, par_chk_en, dvma_en, irq_en, normal_mode;
    logic [2:0]  swirq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // memory models: contents computed from the index
    assign rom_data   = {2'b00, rom_addr} ^ 16'hA5C3;
    assign idrom_data = {3'b101, idrom_addr};

    ctlsp_regdec uut (
        .clk(clk), .rst_n(rst_n), .fc(fc), .addr(addr), .rd(rd), .wr(wr),
        .be(be), .wdata(wdata), .rdata(rdata), .fwd_rd(fwd_rd), .fwd_wr(fwd_wr),
        .rom_addr(rom_addr), .rom_data(rom_data), .idrom_addr(idrom_addr),
        .idrom_data(idrom_data), .berr_cap(berr_cap), .berr_info(berr_info),
        .led_on(led_on), .par_gen_en(par_gen_en), .par_chk_en(par_chk_en),
        .dvma_en(dvma_en), .irq_en(irq_en), .swirq(swirq), .normal_mode(normal_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [23:1] mk_addr(input int hi, input int low3);
        logic [23:1] a;
        a = '0;
        a[15:11] = hi[4:0];
        a[3:1] = low3[2:0];
        return a;
    endfunction

    task automatic do_write(input logic [2:0] f, input logic [23:1] a,
                            input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        fc = f; addr = a; wdata = d; be = b; wr = 1'b1; rd = 1'b0;
        @(negedge clk);
        wr = 1'b0; be = 2'b00;
    endtask

    // sets up a read; results are sampled 1 ns after the falling edge
    task automatic start_read(input logic [2:0] f, input logic [23:1] a);
        @(negedge clk);
        fc = f; addr = a; rd = 1'b1; wr = 1'b0;
        #1;
    endtask

    task automatic end_read();
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        reset_dut();
        #1;
        // R8: reset state
        check("R8 led", led_on, 8'hFF);
        check("R8 ctl", {par_gen_en, par_chk_en, dvma_en, irq_en, swirq, normal_mode}, 0);
        start_read(3'd3, mk_addr(0, 3'b111));
        check("R8 sysen rd", rdata, 0);
        end_read();
        start_read(3'd3, mk_addr(0, 3'b110));
        check("R8 berr rd", rdata, 0);
        end_read();

        // R1/R7/R9: decode sweep in boot state, then normal state
        for (int m = 0; m < 2; m++) begin
            if (m == 1) do_write(3'd3, mk_addr(0, 3'b111), 16'h0080, 2'b01);
            for (int f = 0; f < 8; f++) begin
                for (int o = 0; o < 8; o++) begin
                    bit claim;
                    claim = (f == 3 && o >= 4) || (f == 6 && m == 0);
                    start_read(f[2:0], mk_addr(5, o));
                    check("R1 R9 fwd_rd", fwd_rd, !claim);
                    if (f == 6 && m == 0)
                        check("R7 boot data", rdata, {2'b00, 11'd0, 3'(o)} ^ 16'h0000 ^
                              ({2'b00, 14'(5 << 10 | o)} ^ 16'hA5C3) ^ {2'b00, 11'd0, 3'(o)});
                    end_read();
                end
            end
        end

        // R7: boot word index from high address bits too
        reset_dut();
        begin
            logic [23:1] a;
            a = '0;
            a[14:1] = 14'h2ABC;
            a[20] = 1'b1;
            start_read(3'd6, a);
            check("R7 rom_addr", rom_addr, 14'h2ABC);
            check("R7 rdata", rdata, {2'b00, 14'h2ABC} ^ 16'hA5C3);
            end_read();
        end

        // R2: every ID ROM byte, then write ignored
        for (int i = 0; i < 32; i++) begin
            start_read(3'd3, mk_addr(i, 3'b100));
            check("R2 id byte", rdata, {3'b101, 5'(i), 8'h00});
            end_read();
        end
        do_write(3'd3, mk_addr(3, 3'b100), 16'hFFFF, 2'b11);
        start_read(3'd3, mk_addr(3, 3'b100));
        check("R4 id write ignored", rdata, {3'b101, 5'd3, 8'h00});
        end_read();

        // R3: diagnostic register
        do_write(3'd3, mk_addr(0, 3'b101), 16'hC35A, 2'b01);
        #1;
        check("R3 led", led_on, 8'hA5);
        start_read(3'd3, mk_addr(0, 3'b101));
        check("R3 readback", rdata, 16'h005A);
        end_read();
        do_write(3'd3, mk_addr(0, 3'b101), 16'h00F0, 2'b10);
        #1;
        check("R3 be1 only", led_on, 8'hA5);

        // R9: forwarded writes touch no register
        @(negedge clk);
        fc = 3'd5; addr = mk_addr(0, 3'b101); wdata = 16'h0011; be = 2'b01; wr = 1'b1;
        #1;
        check("R9 fwd_wr other fc", fwd_wr, 1);
        @(negedge clk);
        fc = 3'd3; addr = mk_addr(0, 3'b001);
        #1;
        check("R9 fwd_wr mmu layer", fwd_wr, 1);
        @(negedge clk);
        addr = mk_addr(0, 3'b101);
        #1;
        check("R9 reg write claimed", fwd_wr, 0);
        wdata = 16'h005A;
        @(negedge clk);
        wr = 1'b0; be = 2'b00;
        #1;
        check("R9 diag unchanged", led_on, 8'hA5);

        // R4: capture, ignored write, and coincident capture and write
        @(negedge clk);
        berr_cap = 1'b1; berr_info = 8'h3C;
        @(negedge clk);
        berr_cap = 1'b0;
        do_write(3'd3, mk_addr(0, 3'b110), 16'h00FF, 2'b11);
        start_read(3'd3, mk_addr(0, 3'b110));
        check("R4 write ignored", rdata, 16'h003C);
        end_read();
        @(negedge clk);
        fc = 3'd3; addr = mk_addr(0, 3'b110); wdata = 16'h0011; be = 2'b11; wr = 1'b1;
        berr_cap = 1'b1; berr_info = 8'h77;
        @(negedge clk);
        wr = 1'b0; berr_cap = 1'b0;
        start_read(3'd3, mk_addr(0, 3'b110));
        check("R4 capture wins", rdata, 16'h0077);
        end_read();

        // R5/R6: every system-enable value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            do_write(3'd3, mk_addr(0, 3'b111), {~b, b}, 2'b01);
            do_write(3'd3, mk_addr(0, 3'b111), {b, ~b}, 2'b10);
            #1;
            check("R5 outputs", {par_gen_en, par_chk_en, dvma_en, irq_en, normal_mode},
                  {b[0], b[4], b[5], b[6], b[7]});
            check("R6 swirq", swirq, b[3:1] & {3{b[6]}});
            start_read(3'd3, mk_addr(0, 3'b111));
            check("R5 readback", rdata, {8'h00, b});
            end_read();
        end

        // R8: reset from a busy state
        do_write(3'd3, mk_addr(0, 3'b111), 16'h00FF, 2'b01);
        reset_dut();
        #1;
        check("R8 rereset ctl", {irq_en, swirq, normal_mode, led_on}, {5'b0, 8'hFF});

        done = 1;
        summary();
        $finish;
    end

endmodule